// File: doc/BRIEF.md
# Delay-Slot-Aware Squash Boundary Calculator

This block sits in the commit stage of an out-of-order core whose instruction set has branch delay slots. It has one lane per hardware thread. Each lane takes a squash request from the execute stage. A request carries a sequence number and four qualifier flags: mispredict, taken, conditional delay-slot branch, and include-the-squashing-instruction. From these the lane works out three values. The first is the youngest sequence number that survives, and it goes back to execute. The second is the boundary sequence number used for the reorder-buffer squash command. The third is a flag that says whether the delay-slot instruction behind the branch is killed as well.

The boundary usually matches the youngest survivor. It sits one step younger when a mispredicted branch keeps its delay slot alive. It sits on the branch itself when a taken conditional delay-slot branch must discard its slot. All results are registered. They appear one cycle after the request, together with a single-cycle pulse. The thread lanes run fully in parallel.

Top module: `squash_boundary_calc`

## Requirements
- R1: A request with mispredict=1, taken=1 and cond-slot=1 yields boundary = youngest survivor and sets the kill-slot output to 1.
- R2: A request with mispredict=1 that is not both taken and cond-slot yields boundary = youngest survivor + 1 (the slot survives) and clears the kill-slot output.
- R3: A request with mispredict=0 yields boundary = youngest survivor, and the kill-slot output keeps its previous value.
- R4: The youngest survivor equals the request sequence number minus 1 when include=1, and equals it unchanged when include=0. It never takes the +1 slot adjustment.
- R5: Sequence numbers are 16 bits wide, and every +1 or -1 step wraps modulo 65536 (0 - 1 = 0xFFFF, 0xFFFF + 1 = 0).
- R6: The results of a request taken on a clock edge are visible after that edge. The thread's done pulse is high for exactly the cycle that follows a valid request and is low otherwise.
- R7: The threads are independent. A request on one thread never changes another thread's outputs, and requests arriving together on both threads are each handled in the same cycle.
- R8: After synchronous reset, every pulse, youngest, boundary and kill-slot output is 0.
- R9: While a thread receives no request, its youngest, boundary and kill-slot outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NTHR | Per-thread squash request strobe |
| req_seq | input | NTHR x 16 | Per-thread sequence number of the squashing instruction |
| req_mispred | input | NTHR | Request comes from a branch mispredict |
| req_taken | input | NTHR | The mispredicted branch was taken |
| req_cond_slot | input | NTHR | The branch is a conditional delay-slot branch |
| req_incl | input | NTHR | The squashing instruction itself is also discarded |
| done_pulse | output | NTHR | One-cycle pulse marking fresh results |
| young_seq | output | NTHR x 16 | Youngest surviving sequence number, sent to execute |
| rob_bound | output | NTHR x 16 | Boundary for the reorder-buffer squash |
| kill_slot | output | NTHR | The delay-slot instruction is discarded too |

## Verification
The assertions assume that the taken and cond-slot flags are only meaningful while mispredict is high. They also assume that the input flags are plain known levels in every cycle, including cycles when no request is valid. The stimulus changes inputs only at the falling clock edge. It draws every flag on every cycle from a fixed-seed random source, so the flags are defined even when idle and may take any value. It also forces sequence numbers onto the wrap points 0 and 0xFFFF, and it issues requests on both threads in the same cycle as well as on one thread alone.

// File: rtl/sqb_pkg.sv
package sqb_pkg;
    localparam int SEQ_W = 16;

    typedef logic [SEQ_W-1:0] seq_t;

    typedef struct packed {
        logic valid;
        seq_t seq;
        logic mispred;
        logic taken;
        logic cond_slot;
        logic incl;
    } sq_req_t;

    typedef enum logic [1:0] {
        SQ_PLAIN     = 2'd0,
        SQ_KEEP_SLOT = 2'd1,
        SQ_KILL_SLOT = 2'd2
    } sq_kind_e;

    typedef struct packed {
        sq_kind_e kind;
        seq_t     young;
        seq_t     bound;
        logic     kill_upd;
        logic     kill_val;
    } sq_calc_t;

    typedef struct packed {
        logic pulse;
        seq_t young;
        seq_t bound;
        logic kill;
    } sq_resp_t;

    function automatic sq_kind_e sq_classify(sq_req_t r);
        if (!r.mispred)
            return SQ_PLAIN;
        else if (r.taken && r.cond_slot)
            return SQ_KILL_SLOT;
        else
            return SQ_KEEP_SLOT;
    endfunction

    function automatic seq_t sq_step(seq_t s, logic up, logic en);
        if (!en)
            return s;
        else if (up)
            return s + seq_t'(1);
        else
            return s - seq_t'(1);
    endfunction
endpackage

// File: rtl/sqb_boundary_calc.sv
module sqb_boundary_calc
    import sqb_pkg::*;
(
    input  sq_req_t  req,
    output sq_calc_t calc
);
    sq_kind_e kind;
    seq_t     young;

    always_comb begin
        kind  = sq_classify(req);
        young = sq_step(req.seq, 1'b0, req.incl);
        calc.kind  = kind;
        calc.young = young;
        unique case (kind)
            SQ_KILL_SLOT: begin
                calc.bound    = young;
                calc.kill_upd = 1'b1;
                calc.kill_val = 1'b1;
            end
            SQ_KEEP_SLOT: begin
                calc.bound    = sq_step(young, 1'b1, 1'b1);
                calc.kill_upd = 1'b1;
                calc.kill_val = 1'b0;
            end
            default: begin
                calc.bound    = young;
                calc.kill_upd = 1'b0;
                calc.kill_val = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/sqb_lane.sv
module sqb_lane
    import sqb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  sq_req_t  req,
    output sq_resp_t resp
);
    sq_calc_t calc;
    sq_resp_t state_q;

    sqb_boundary_calc u_calc (
        .req  (req),
        .calc (calc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q.pulse <= req.valid;
            if (req.valid) begin
                state_q.young <= calc.young;
                state_q.bound <= calc.bound;
                if (calc.kill_upd)
                    state_q.kill <= calc.kill_val;
            end
        end
    end

    assign resp = state_q;

    // R6: pulse follows a valid request by exactly one cycle
    p_pulse_after_req_r6: assert property (@(posedge clk) disable iff (rst)
        req.valid |=> resp.pulse);
    p_no_pulse_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !req.valid |=> !resp.pulse);

    // R1: taken conditional slot branch kills the slot
    p_kill_set_r1: assert property (@(posedge clk) disable iff (rst)
        (req.valid && req.mispred && req.taken && req.cond_slot)
        |=> (resp.kill && resp.bound == resp.young));

    // R2: other mispredicts keep the slot, boundary one past survivor
    p_keep_slot_r2: assert property (@(posedge clk) disable iff (rst)
        (req.valid && req.mispred && !(req.taken && req.cond_slot))
        |=> (!resp.kill && resp.bound == resp.young + seq_t'(1)));

    // R3: a plain squash leaves the kill flag untouched
    p_kill_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (req.valid && !req.mispred) |=> ($stable(resp.kill) && resp.bound == resp.young));

    // R4: survivor is the request number, minus one only when include is set
    p_young_r4: assert property (@(posedge clk) disable iff (rst)
        req.valid |=> (resp.young == $past(req.seq) - seq_t'($past(req.incl))));

    // R9: idle thread holds its results
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !req.valid |=> ($stable(resp.young) && $stable(resp.bound) && $stable(resp.kill)));
endmodule

// File: rtl/squash_boundary_calc.sv
module squash_boundary_calc
    import sqb_pkg::*;
#(
    parameter int NTHR = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NTHR-1:0]             req_valid,
    input  logic [NTHR-1:0][SEQ_W-1:0]  req_seq,
    input  logic [NTHR-1:0]             req_mispred,
    input  logic [NTHR-1:0]             req_taken,
    input  logic [NTHR-1:0]             req_cond_slot,
    input  logic [NTHR-1:0]             req_incl,
    output logic [NTHR-1:0]             done_pulse,
    output logic [NTHR-1:0][SEQ_W-1:0]  young_seq,
    output logic [NTHR-1:0][SEQ_W-1:0]  rob_bound,
    output logic [NTHR-1:0]             kill_slot
);
    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        sq_req_t  lane_req;
        sq_resp_t lane_resp;

        always_comb begin
            lane_req.valid     = req_valid[t];
            lane_req.seq       = req_seq[t];
            lane_req.mispred   = req_mispred[t];
            lane_req.taken     = req_taken[t];
            lane_req.cond_slot = req_cond_slot[t];
            lane_req.incl      = req_incl[t];
        end

        sqb_lane u_lane (
            .clk  (clk),
            .rst  (rst),
            .req  (lane_req),
            .resp (lane_resp)
        );

        assign done_pulse[t] = lane_resp.pulse;
        assign young_seq[t]  = lane_resp.young;
        assign rob_bound[t]  = lane_resp.bound;
        assign kill_slot[t]  = lane_resp.kill;
    end
endmodule

// File: tb/squash_boundary_calc_bench.sv
module squash_boundary_calc_bench;
    localparam int NT = 2;

    logic clk = 1'b0;
    logic rst;
    logic [NT-1:0]       req_valid, req_mispred, req_taken, req_cond_slot, req_incl;
    logic [NT-1:0][15:0] req_seq;
    logic [NT-1:0]       done_pulse, kill_slot;
    logic [NT-1:0][15:0] young_seq, rob_bound;

    int checks = 0;
    int bad = 0;

    logic [15:0] e_young [NT];
    logic [15:0] e_bound [NT];
    logic        e_kill  [NT];
    logic        e_pulse [NT];
    string       e_tag   [NT];

    always #5 clk = ~clk;

    squash_boundary_calc u_squash_boundary_calc (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_seq(req_seq),
        .req_mispred(req_mispred), .req_taken(req_taken),
        .req_cond_slot(req_cond_slot), .req_incl(req_incl),
        .done_pulse(done_pulse), .young_seq(young_seq),
        .rob_bound(rob_bound), .kill_slot(kill_slot)
    );

    function automatic logic [15:0] f_young(logic [15:0] s, logic inc);
        return inc ? s - 16'd1 : s;
    endfunction

    function automatic logic [15:0] f_bound(logic [15:0] s, logic inc, logic mp, logic tk, logic cs);
        logic [15:0] y = f_young(s, inc);
        return (mp && !(tk && cs)) ? y + 16'd1 : y;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all();
        for (int t = 0; t < NT; t++) begin
            chk("R6", "pulse", int'(done_pulse[t]), int'(e_pulse[t]));
            chk(e_pulse[t] ? "R4" : e_tag[t], "young", int'(young_seq[t]), int'(e_young[t]));
            chk(e_tag[t], "bound", int'(rob_bound[t]), int'(e_bound[t]));
            chk(e_tag[t], "kill", int'(kill_slot[t]), int'(e_kill[t]));
        end
    endtask

    // apply inputs at negedge, update model, check at next negedge
    task automatic step();
        for (int t = 0; t < NT; t++) begin
            e_pulse[t] = req_valid[t];
            if (req_valid[t]) begin
                e_young[t] = f_young(req_seq[t], req_incl[t]);
                e_bound[t] = f_bound(req_seq[t], req_incl[t], req_mispred[t], req_taken[t], req_cond_slot[t]);
                if (req_mispred[t]) begin
                    e_kill[t] = req_taken[t] && req_cond_slot[t];
                    e_tag[t]  = e_kill[t] ? "R1" : "R2";
                end else begin
                    e_tag[t] = "R3";
                end
                if (req_seq[t] == 16'h0000 || req_seq[t] == 16'hFFFF)
                    e_tag[t] = "R5";
            end else begin
                e_tag[t] = req_valid[1-t] ? "R7" : "R9";
            end
        end
        @(negedge clk);
        check_all();
    endtask

    task automatic set_req(int t, logic v, logic [15:0] s, logic mp, logic tk, logic cs, logic inc);
        req_valid[t] = v; req_seq[t] = s; req_mispred[t] = mp;
        req_taken[t] = tk; req_cond_slot[t] = cs; req_incl[t] = inc;
    endtask

    initial begin
        #1_000_000;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        int seed;
        seed = 1234;
        void'($urandom(seed));
        rst = 1'b1;
        for (int t = 0; t < NT; t++) begin
            set_req(t, 0, 16'h0, 0, 0, 0, 0);
            e_young[t] = '0; e_bound[t] = '0; e_kill[t] = 1'b0;
            e_pulse[t] = 1'b0; e_tag[t] = "R8";
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all(); // R8 reset state
        rst = 1'b0;

        // R1 on thread 0, R2 on thread 1, same cycle (R7)
        set_req(0, 1, 16'h0100, 1, 1, 1, 0);
        set_req(1, 1, 16'h0200, 1, 1, 0, 1);
        step();
        // R3 kill hold on thread 0, thread 1 idle
        set_req(0, 1, 16'h0300, 0, 1, 1, 1);
        set_req(1, 0, 16'h0, 1, 1, 1, 1);
        step();
        // R5 wraps: 0 with include, FFFF keep-slot
        set_req(0, 1, 16'h0000, 0, 0, 0, 1);
        set_req(1, 1, 16'hFFFF, 1, 0, 1, 0);
        step();
        set_req(0, 1, 16'h0000, 1, 0, 0, 1);
        set_req(1, 1, 16'hFFFF, 1, 1, 1, 1);
        step();
        // R9 idle hold with noisy flags
        set_req(0, 0, 16'h1234, 1, 1, 1, 1);
        set_req(1, 0, 16'h4321, 1, 0, 0, 1);
        step();

        for (int i = 0; i < 400; i++) begin
            for (int t = 0; t < NT; t++) begin
                logic [15:0] s;
                s = 16'($urandom);
                if ($urandom_range(0, 9) == 0) s = 16'hFFFF;
                else if ($urandom_range(0, 9) == 0) s = 16'h0000;
                set_req(t, 1'($urandom_range(0, 2) != 0), s,
                        1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
            end
            step();
        end

        set_req(0, 0, 16'h0, 0, 0, 0, 0);
        set_req(1, 0, 16'h0, 0, 0, 0, 0);
        step();
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule